// File: doc/BRIEF.md
# Frequency Counter Acquisition Sequencer

This block is the control state machine of a wide-range frequency counter. On each start strobe it first holds both phase-lock loops off and watches a flag that says whether the input can be counted directly (roughly 10 Hz up to about 225 MHz). If that flag comes up inside a window of about 10 ms, the measurement ends on the direct path and the loops are never switched on.

If the window runs out, the sequencer selects the heterodyne path (about 225 MHz up to 18 GHz) and enables the input loop. Only after the input loop reports lock does it enable the transfer loop and wait for that loop's lock. With both locks held, it latches the harmonic number N and the loop frequency F1 and reports F = N·F1 − 20 MHz. A missing input lock ends the run with a no-signal status. A lock that drops mid-measurement sends the sequencer back to the search.

Top module: `freq_acq_seq`

## Requirements
- R1: After reset, every output is 0: both loop enables, path select, done, mode, no-signal, error and frequency.
- R2: In the cycle after a start strobe, both loop enables, path select and done are 0. They stay 0 while the direct window runs.
- R3: If the direct flag is seen in the k-th cycle after the start edge (k = 1..DIRECT_WAIT), done is high one cycle later with mode 0 (0 = direct, 1 = transfer), frequency 0, error 0, no-signal 0 and path select 0. No loop is enabled during the run.
- R4: Without the direct flag, the input loop enable and path select go to 1 exactly DIRECT_WAIT = CLK_HZ/100 cycles after the start edge. The transfer loop enable stays 0 at that point.
- R5: If the direct flag arrives in the last cycle of the window, the direct outcome wins over the fall-back.
- R6: The transfer loop enable goes high only in the cycle after input lock is seen. A transfer lock seen while input lock is absent has no effect.
- R7: With both locks held, done rises two cycles after the transfer lock is first seen. At that point mode is 1 and frequency = N·F1 − 20 MHz, with N an 8-bit and F1 a 32-bit unsigned input and a 40-bit result.
- R8: If N·F1 is below 20 MHz, done comes with error 1 and frequency 0. If N·F1 equals 20 MHz exactly, frequency is 0 and error is 0.
- R9: If input lock is not seen within LOCK_WAIT cycles of entering the search, done is high in the LOCK_WAIT-th cycle with mode 1, no-signal 1, error 0 and frequency 0.
- R10: If a lock drops before the result is issued, no done appears. The transfer loop enable returns to 0 while the input loop enable stays 1.
- R11: A start strobe in any state aborts the current run and restarts the direct window from zero.
- R12: Done is high for one cycle only. Mode, no-signal, error and frequency hold their values until the next start strobe, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a measurement (aborts any run in progress) |
| direct_sig_i | input | 1 | A direct-countable signal is present |
| in_lock_i | input | 1 | Input loop lock indication |
| xfer_lock_i | input | 1 | Transfer loop lock indication |
| harm_n_i | input | 8 | Harmonic number N |
| f1_hz_i | input | 32 | Input loop frequency F1 in Hz |
| in_loop_en_o | output | 1 | Enable for the input loop |
| xfer_loop_en_o | output | 1 | Enable for the transfer loop |
| path_xfer_o | output | 1 | Path select: 0 direct, 1 transfer |
| freq_o | output | 40 | Computed frequency in Hz |
| done_o | output | 1 | One-cycle completion strobe |
| mode_xfer_o | output | 1 | Path used by the finished run |
| nosig_o | output | 1 | Run ended without input lock |
| err_o | output | 1 | N·F1 was below the offset |

## Verification
Two events can fall in the same cycle. The direct-signal detection can coincide with the expiry of the direct window, and a lock loss can coincide with the cycle that would issue the result. The bench sweeps the arrival of the direct flag over every cycle of a shortened window, including its last cycle, and expects done with mode 0 and no loop enable whenever the flag lands inside the window. It also drops the transfer lock in the cycle before the result is due, and expects no done and a return to the search state.

// File: rtl/freq_acq_pkg.sv
package freq_acq_pkg;

    localparam int HARM_W = 8;
    localparam int F1_W   = 32;
    localparam int FREQ_W = HARM_W + F1_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_SEARCH,
        ST_XWAIT,
        ST_CALC
    } acq_state_e;

    typedef struct packed {
        logic              under;
        logic [FREQ_W-1:0] value;
    } calc_res_t;

    typedef struct packed {
        logic              mode_xfer;
        logic              no_sig;
        logic              err;
        logic [FREQ_W-1:0] freq;
    } acq_report_t;

    // Subtract the heterodyne offset, flagging a product below it.
    function automatic calc_res_t sub_offset(input logic [FREQ_W-1:0] prod,
                                             input logic [FREQ_W-1:0] off);
        calc_res_t r;
        r.under = (prod < off);
        r.value = r.under ? '0 : (prod - off);
        return r;
    endfunction

    function automatic logic loops_on(input acq_state_e s);
        return (s == ST_SEARCH) || (s == ST_XWAIT) || (s == ST_CALC);
    endfunction

    function automatic logic xfer_on(input acq_state_e s);
        return (s == ST_XWAIT) || (s == ST_CALC);
    endfunction

endpackage

// File: rtl/acq_timer.sv
module acq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (run && (count_q != LAST)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign expire = run && (count_q == LAST);
endmodule

// File: rtl/acq_calc.sv
module acq_calc
    import freq_acq_pkg::*;
#(
    parameter longint unsigned OFFSET_HZ = 64'd20_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HARM_W-1:0] harm_n,
    input  logic [F1_W-1:0]   f1_hz,
    output calc_res_t         res
);
    localparam logic [FREQ_W-1:0] OFF = FREQ_W'(OFFSET_HZ);

    logic [FREQ_W-1:0] prod_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else if (load) begin
            prod_q <= FREQ_W'(harm_n) * FREQ_W'(f1_hz);
        end
    end

    assign res = sub_offset(prod_q, OFF);
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
    import freq_acq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        direct_sig,
    input  logic        in_lock,
    input  logic        xfer_lock,
    input  logic        look_exp,
    input  logic        lock_exp,
    input  calc_res_t   calc_res,
    output acq_state_e  st_q,
    output acq_state_e  st_d,
    output logic        load_calc,
    output logic        done,
    output logic        path_xfer,
    output acq_report_t report
);
    logic        done_d;
    logic        path_d;
    acq_report_t rep_d;

    always_comb begin
        st_d      = st_q;
        done_d    = 1'b0;
        path_d    = path_xfer;
        rep_d     = report;
        load_calc = 1'b0;
        if (start) begin
            st_d   = ST_LOOK;
            path_d = 1'b0;
            rep_d  = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: ;
                ST_LOOK: begin
                    if (direct_sig) begin
                        st_d   = ST_IDLE;
                        done_d = 1'b1;
                        rep_d  = '0;
                    end else if (look_exp) begin
                        st_d   = ST_SEARCH;
                        path_d = 1'b1;
                    end
                end
                ST_SEARCH: begin
                    if (in_lock) begin
                        st_d = ST_XWAIT;
                    end else if (lock_exp) begin
                        st_d            = ST_IDLE;
                        done_d          = 1'b1;
                        rep_d           = '0;
                        rep_d.mode_xfer = 1'b1;
                        rep_d.no_sig    = 1'b1;
                    end
                end
                ST_XWAIT: begin
                    if (!in_lock) begin
                        st_d = ST_SEARCH;
                    end else if (xfer_lock) begin
                        st_d      = ST_CALC;
                        load_calc = 1'b1;
                    end else if (lock_exp) begin
                        st_d            = ST_IDLE;
                        done_d          = 1'b1;
                        rep_d           = '0;
                        rep_d.mode_xfer = 1'b1;
                        rep_d.no_sig    = 1'b1;
                    end
                end
                ST_CALC: begin
                    if (!in_lock || !xfer_lock) begin
                        st_d = ST_SEARCH;
                    end else begin
                        st_d            = ST_IDLE;
                        done_d          = 1'b1;
                        rep_d.mode_xfer = 1'b1;
                        rep_d.no_sig    = 1'b0;
                        rep_d.err       = calc_res.under;
                        rep_d.freq      = calc_res.value;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            done      <= 1'b0;
            path_xfer <= 1'b0;
            report    <= '0;
        end else begin
            st_q      <= st_d;
            done      <= done_d;
            path_xfer <= path_d;
            report    <= rep_d;
        end
    end
endmodule

// File: rtl/freq_acq_seq.sv
module freq_acq_seq
    import freq_acq_pkg::*;
#(
    parameter int              CLK_HZ    = 50_000_000,
    parameter int              LOCK_WAIT = 100_000,
    parameter longint unsigned OFFSET_HZ = 64'd20_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              direct_sig_i,
    input  logic              in_lock_i,
    input  logic              xfer_lock_i,
    input  logic [HARM_W-1:0] harm_n_i,
    input  logic [F1_W-1:0]   f1_hz_i,
    output logic              in_loop_en_o,
    output logic              xfer_loop_en_o,
    output logic              path_xfer_o,
    output logic [FREQ_W-1:0] freq_o,
    output logic              done_o,
    output logic              mode_xfer_o,
    output logic              nosig_o,
    output logic              err_o
);
    localparam int DIRECT_WAIT = (CLK_HZ / 100 > 0) ? CLK_HZ / 100 : 1;

    acq_state_e  st_q, st_d;
    logic        look_exp, lock_exp, load_calc;
    logic        look_clr, lock_clr, lock_run;
    calc_res_t   calc_res;
    acq_report_t report;

    assign look_clr = start_i || (st_q != ST_LOOK);
    assign lock_run = (st_q == ST_SEARCH) || (st_q == ST_XWAIT);
    assign lock_clr = start_i || !lock_run || (st_d != st_q);

    acq_timer #(.LIMIT(DIRECT_WAIT)) u_look_tmr (
        .clk    (clk),
        .rst    (rst),
        .clr    (look_clr),
        .run    (st_q == ST_LOOK),
        .expire (look_exp)
    );

    acq_timer #(.LIMIT(LOCK_WAIT)) u_lock_tmr (
        .clk    (clk),
        .rst    (rst),
        .clr    (lock_clr),
        .run    (lock_run),
        .expire (lock_exp)
    );

    acq_calc #(.OFFSET_HZ(OFFSET_HZ)) u_calc (
        .clk    (clk),
        .rst    (rst),
        .load   (load_calc),
        .harm_n (harm_n_i),
        .f1_hz  (f1_hz_i),
        .res    (calc_res)
    );

    acq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .direct_sig (direct_sig_i),
        .in_lock    (in_lock_i),
        .xfer_lock  (xfer_lock_i),
        .look_exp   (look_exp),
        .lock_exp   (lock_exp),
        .calc_res   (calc_res),
        .st_q       (st_q),
        .st_d       (st_d),
        .load_calc  (load_calc),
        .done       (done_o),
        .path_xfer  (path_xfer_o),
        .report     (report)
    );

    assign in_loop_en_o   = loops_on(st_q);
    assign xfer_loop_en_o = xfer_on(st_q);
    assign freq_o         = report.freq;
    assign mode_xfer_o    = report.mode_xfer;
    assign nosig_o        = report.no_sig;
    assign err_o          = report.err;
endmodule

// File: rtl/freq_acq_seq_chk.sv
module freq_acq_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        in_lock_i,
    input logic        in_loop_en_o,
    input logic        xfer_loop_en_o,
    input logic        path_xfer_o,
    input logic [39:0] freq_o,
    input logic        done_o,
    input logic        mode_xfer_o,
    input logic        nosig_o,
    input logic        err_o
);
    assert_start_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!in_loop_en_o && !xfer_loop_en_o && !path_xfer_o && !done_o));

    assert_direct_clean_R3: assert property (@(posedge clk) disable iff (rst)
        (done_o && !mode_xfer_o) |-> (!path_xfer_o && !in_loop_en_o && !err_o && !nosig_o));

    assert_loop_has_path_R4: assert property (@(posedge clk) disable iff (rst)
        in_loop_en_o |-> path_xfer_o);

    assert_xfer_needs_input_R6: assert property (@(posedge clk) disable iff (rst)
        xfer_loop_en_o |-> in_loop_en_o);

    assert_xfer_after_lock_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_loop_en_o) |-> $past(in_lock_i));

    assert_err_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (freq_o == 40'd0 && !nosig_o && mode_xfer_o));

    assert_nosig_form_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && nosig_o) |-> (mode_xfer_o && !err_o && freq_o == 40'd0));

    assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

bind freq_acq_seq freq_acq_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .in_lock_i      (in_lock_i),
    .in_loop_en_o   (in_loop_en_o),
    .xfer_loop_en_o (xfer_loop_en_o),
    .path_xfer_o    (path_xfer_o),
    .freq_o         (freq_o),
    .done_o         (done_o),
    .mode_xfer_o    (mode_xfer_o),
    .nosig_o        (nosig_o),
    .err_o          (err_o)
);

// File: tb/sim_freq_acq_seq.sv
module sim_freq_acq_seq;
    localparam int D  = 10;   // CLK_HZ/100 with CLK_HZ=1000
    localparam int LW = 12;
    localparam longint unsigned OFF = 64'd20_000_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, direct_sig_i = 1'b0, in_lock_i = 1'b0, xfer_lock_i = 1'b0;
    logic [7:0]  harm_n_i = '0;
    logic [31:0] f1_hz_i = '0;
    logic        in_loop_en_o, xfer_loop_en_o, path_xfer_o, done_o, mode_xfer_o, nosig_o, err_o;
    logic [39:0] freq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    freq_acq_seq #(.CLK_HZ(1000), .LOCK_WAIT(LW), .OFFSET_HZ(OFF)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .direct_sig_i(direct_sig_i),
        .in_lock_i(in_lock_i), .xfer_lock_i(xfer_lock_i), .harm_n_i(harm_n_i),
        .f1_hz_i(f1_hz_i), .in_loop_en_o(in_loop_en_o), .xfer_loop_en_o(xfer_loop_en_o),
        .path_xfer_o(path_xfer_o), .freq_o(freq_o), .done_o(done_o),
        .mode_xfer_o(mode_xfer_o), .nosig_o(nosig_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic go_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic to_search();
        direct_sig_i = 0; in_lock_i = 0; xfer_lock_i = 0;
        go_start();
        repeat (D) @(negedge clk);
    endtask

    task automatic run_xfer(input logic [7:0] n, input logic [31:0] f1);
        logic [39:0] prod;
        logic        under;
        logic [39:0] expf;
        prod  = 40'(n) * 40'(f1);
        under = prod < 40'(OFF);
        expf  = under ? 40'd0 : prod - 40'(OFF);
        to_search();
        harm_n_i = n; f1_hz_i = f1; in_lock_i = 1;
        @(negedge clk); xfer_lock_i = 1;
        @(negedge clk);
        chk(done_o == 0, "R7 early done", 64'(done_o), 0);
        @(negedge clk);
        chk(done_o && mode_xfer_o, "R7 done/mode", {62'd0, done_o, mode_xfer_o}, 3);
        chk(freq_o == expf, "R7 R8 freq", 64'(freq_o), 64'(expf));
        chk(err_o == under, "R8 err", 64'(err_o), 64'(under));
        in_lock_i = 0; xfer_lock_i = 0;
        @(negedge clk);
        chk(done_o == 0 && freq_o == expf, "R12 one-cycle done, held result",
            64'(done_o), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0]  n_set  [12] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd5, 8'd7, 8'd8, 8'd15, 8'd16, 8'd100, 8'd200, 8'd255};
        logic [31:0] f1_set [7]  = '{32'd0, 32'd1, 32'd10_000_000, 32'd19_999_999, 32'd20_000_000, 32'd123_456_789, 32'hFFFF_FFFF};
        int cnt;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk({in_loop_en_o, xfer_loop_en_o, path_xfer_o, done_o, mode_xfer_o, nosig_o, err_o} == 0
            && freq_o == 0, "R1 reset outputs", 64'(freq_o), 0);

        // R3 / R5 / R2: direct flag arriving at each cycle of the window
        for (int k = 0; k <= D; k++) begin
            direct_sig_i = 0;
            go_start();
            chk(!in_loop_en_o && !path_xfer_o && !done_o, "R2 after start", 64'(in_loop_en_o), 0);
            for (int j = 0; j < k; j++) begin
                chk(!in_loop_en_o && !xfer_loop_en_o && !path_xfer_o, "R2 window quiet",
                    {61'd0, in_loop_en_o, xfer_loop_en_o, path_xfer_o}, 0);
                @(negedge clk);
            end
            direct_sig_i = 1;
            @(negedge clk);
            if (k < D) begin
                chk(done_o && !mode_xfer_o && !path_xfer_o && !in_loop_en_o && freq_o == 0
                    && !err_o && !nosig_o, (k == D-1) ? "R5 direct wins at expiry" : "R3 direct done",
                    {59'd0, done_o, mode_xfer_o, path_xfer_o, in_loop_en_o, err_o}, 64'h10);
            end else begin
                chk(!done_o && in_loop_en_o, "R3 late direct ignored", 64'(done_o), 0);
            end
            direct_sig_i = 0;
        end

        // R4: exact timeout length
        direct_sig_i = 0; in_lock_i = 0; xfer_lock_i = 0;
        go_start();
        cnt = 0;
        while (!in_loop_en_o && cnt < 5*D) begin @(negedge clk); cnt++; end
        chk(cnt == D, "R4 window length", 64'(cnt), 64'(D));
        chk(path_xfer_o && !xfer_loop_en_o, "R4 path/loops", {62'd0, path_xfer_o, xfer_loop_en_o}, 2);

        // R9: no input lock
        to_search();
        for (int j = 1; j < LW; j++) begin
            @(negedge clk);
            chk(!done_o, "R9 no early nosig", 64'(done_o), 0);
        end
        @(negedge clk);
        chk(done_o && nosig_o && mode_xfer_o && !err_o && freq_o == 0, "R9 nosig done",
            {60'd0, done_o, nosig_o, mode_xfer_o, err_o}, 64'hE);

        // R6: transfer lock alone has no effect
        to_search();
        xfer_lock_i = 1;
        repeat (3) begin
            @(negedge clk);
            chk(!xfer_loop_en_o && !done_o, "R6 xfer lock ignored", 64'(xfer_loop_en_o), 0);
        end
        harm_n_i = 8'd4; f1_hz_i = 32'd500_000_000;
        in_lock_i = 1;
        @(negedge clk);
        chk(xfer_loop_en_o, "R6 xfer enable after input lock", 64'(xfer_loop_en_o), 1);
        @(negedge clk);
        @(negedge clk);
        chk(done_o && freq_o == 40'd1_980_000_000, "R7 result after ordered locks", 64'(freq_o), 64'd1_980_000_000);
        in_lock_i = 0; xfer_lock_i = 0;

        // R10: lock drops
        to_search();
        in_lock_i = 1;
        @(negedge clk);
        chk(xfer_loop_en_o, "R10 in xwait", 64'(xfer_loop_en_o), 1);
        in_lock_i = 0;
        @(negedge clk);
        chk(!xfer_loop_en_o && in_loop_en_o && !done_o, "R10 drop in xwait", {62'd0, xfer_loop_en_o, in_loop_en_o}, 1);
        in_lock_i = 1;
        @(negedge clk); xfer_lock_i = 1;
        @(negedge clk); xfer_lock_i = 0;
        @(negedge clk);
        chk(!done_o && !xfer_loop_en_o && in_loop_en_o, "R10 drop before result",
            {61'd0, done_o, xfer_loop_en_o, in_loop_en_o}, 1);
        in_lock_i = 0;

        // R11: restart mid-search
        to_search();
        repeat (3) @(negedge clk);
        go_start();
        chk(!in_loop_en_o && !path_xfer_o, "R11 abort", {62'd0, in_loop_en_o, path_xfer_o}, 0);
        cnt = 0;
        while (!in_loop_en_o && cnt < 5*D) begin @(negedge clk); cnt++; end
        chk(cnt == D, "R11 window restarted", 64'(cnt), 64'(D));

        // R7 / R8 sweep
        foreach (n_set[a]) foreach (f1_set[b]) run_xfer(n_set[a], f1_set[b]);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule